// File: doc/BRIEF.md
# Euler-Split Edge Colorer for Clos Middle-Stage Routing

This block assigns every connection of a three-stage Clos network, built with as many middle switches as each first-stage switch has inputs, to one middle switch so that no two connections share a middle switch at any first-stage or third-stage switch. Each connection is an edge of a bipartite multigraph. The left vertices are first-stage switches and the right vertices are third-stage switches. The graph must be regular with degree `DEG`, a power of two. The middle switch chosen for an edge is its color, a value in 0 to `DEG`-1.

Software or a scheduler loads the edge list through a write port while the block is idle, then pulses `start`. The block runs log2(`DEG`) levels. At each level it walks closed tours through the edges that still share the same color prefix. It marks each edge it crosses as used and writes the current level's color bit as 0 and 1 on alternate steps. Because every tour in a bipartite graph has even length, each vertex ends the level with half its edges on each side of the split. After the last level each color class is a perfect matching. A one-cycle `done` pulse then marks the colors as valid, and they are read back through a combinational read port.

Top module: `euler_edge_colorer`

## Requirements
- R1: After `done`, no two edges with the same left vertex have the same color, and no two edges with the same right vertex have the same color, even where the edges run in parallel between one vertex pair.
- R2: Every color lies in 0 to `DEG`-1, and each color is carried by exactly `NV` edges.
- R3: When `wr_en` is high and `busy` is low, the clock edge stores `wr_left` and `wr_right` as the endpoints of edge `wr_idx`. A later write to the same index replaces the earlier one.
- R4: A `start` pulse while `busy` is low raises `busy` on the next clock edge (for `DEG` greater than 1).
- R5: `done` is high for exactly one cycle per run. It rises in the same cycle that `busy` falls, with `busy` low. It comes no later than log2(`DEG`)·(2·`NV`·`DEG`+1)+1 cycles after the start edge.
- R6: Writes and `start` pulses that arrive while `busy` is high are ignored. A run disturbed this way produces the same colors as an undisturbed run on the same graph.
- R7: Reset drives `busy` and `done` low and every color to 0. While the block is idle and `start` is low, the color of an edge shown on `rd_color` for index `rd_idx` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Edge write strobe |
| wr_idx | input | clog2(NV·DEG) | Edge index to write |
| wr_left | input | clog2(NV) | First-stage switch of the edge |
| wr_right | input | clog2(NV) | Third-stage switch of the edge |
| start | input | 1 | Begin coloring the loaded edges |
| busy | output | 1 | Coloring run in progress |
| done | output | 1 | One-cycle pulse when the colors are final |
| rd_idx | input | clog2(NV·DEG) | Edge index to read |
| rd_color | output | max(1, log2 DEG) | Middle switch assigned to edge `rd_idx` |

## Verification
The bench builds the block with `NV`=4 and `DEG`=4, so there are sixteen edges and two split levels. A prefix inherited from the first level has to steer the walk at the second level. The test graphs include a complete bipartite pattern, a graph made only of four-fold parallel edges, and graphs made of doubled edges. Their edge orders are permuted, so the seed search and the per-vertex search both meet edges in scattered index positions. Each graph is first written with bogus endpoints and then overwritten. A rerun with an attempted write and a repeated start in the middle of the run shows whether the edge memory or the run was disturbed.

// File: rtl/ec_pkg.sv
package ec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_WALK = 2'd2
  } ec_state_e;
endpackage

// File: rtl/ec_find_first.sv
module ec_find_first #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ec_edge_store.sv
module ec_edge_store #(
  parameter int NV  = 4,
  parameter int DEG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [EIW-1:0]           wr_idx,
  input  logic [VW-1:0]            wr_left,
  input  logic [VW-1:0]            wr_right,
  input  logic                     clr_used,
  input  logic                     clr_color,
  input  logic                     set_en,
  input  logic [EIW-1:0]           set_idx,
  input  logic [CW-1:0]            set_lvl,
  input  logic                     set_val,
  output logic [NE-1:0][VW-1:0]    left_q,
  output logic [NE-1:0][VW-1:0]    right_q,
  output logic [NE-1:0][CW-1:0]    color_q,
  output logic [NE-1:0]            used_q
);
  localparam int NE  = NV * DEG;
  localparam int EIW = (NE > 1) ? $clog2(NE) : 1;
  localparam int VW  = (NV > 1) ? $clog2(NV) : 1;
  localparam int LOG = $clog2(DEG);
  localparam int CW  = (LOG > 0) ? LOG : 1;

  // Endpoint storage: plain memory, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      left_q[wr_idx]  <= wr_left;
      right_q[wr_idx] <= wr_right;
    end
  end

  // Per-edge walk state and color prefix.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
      used_q  <= '0;
    end else begin
      if (clr_used) begin
        used_q <= '0;
      end else if (set_en) begin
        used_q[set_idx] <= 1'b1;
      end
      if (clr_color) begin
        color_q <= '0;
      end else if (set_en) begin
        color_q[set_idx][set_lvl] <= set_val;
      end
    end
  end
endmodule

// File: rtl/euler_edge_colorer.sv
module euler_edge_colorer #(
  parameter int NV  = 4,
  parameter int DEG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [EIW-1:0]         wr_idx,
  input  logic [VW-1:0]          wr_left,
  input  logic [VW-1:0]          wr_right,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  input  logic [EIW-1:0]         rd_idx,
  output logic [CW-1:0]          rd_color
);
  import ec_pkg::*;

  localparam int NE  = NV * DEG;
  localparam int EIW = (NE > 1) ? $clog2(NE) : 1;
  localparam int VW  = (NV > 1) ? $clog2(NV) : 1;
  localparam int LOG = $clog2(DEG);
  localparam int CW  = (LOG > 0) ? LOG : 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // Control state.
  ec_state_e         state_q, state_d;
  logic [CW-1:0]     level_q, level_d;
  logic [VW-1:0]     cur_v_q, cur_v_d;
  logic              side_q, side_d;   // 0: at a left vertex, 1: at a right vertex
  logic              half_q, half_d;   // bit value for the next edge crossed
  logic [CW-1:0]     prefix_q, prefix_d;
  logic              done_q, done_d;

  // Edge store interface.
  logic [NE-1:0][VW-1:0] left_q, right_q;
  logic [NE-1:0][CW-1:0] color_q;
  logic [NE-1:0]         used_q;
  logic                  clr_used, clr_color, set_en, set_val;
  logic [EIW-1:0]        set_idx;
  logic                  wr_ok;

  assign wr_ok = wr_en && (state_q == ST_IDLE);

  ec_edge_store #(.NV(NV), .DEG(DEG)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_ok),
    .wr_idx    (wr_idx),
    .wr_left   (wr_left),
    .wr_right  (wr_right),
    .clr_used  (clr_used),
    .clr_color (clr_color),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .set_lvl   (level_q),
    .set_val   (set_val),
    .left_q    (left_q),
    .right_q   (right_q),
    .color_q   (color_q),
    .used_q    (used_q)
  );

  // Prefix mask: color bits below the current level.
  logic [CW-1:0] lvl_mask;
  always_comb begin
    for (int b = 0; b < CW; b++) lvl_mask[b] = (b < int'(level_q));
  end

  // Candidate vectors, one slot per edge.
  logic [NE-1:0] seed_req, walk_req;
  for (genvar e = 0; e < NE; e++) begin : g_req
    logic at_cur;
    assign at_cur      = side_q ? (right_q[e] == cur_v_q) : (left_q[e] == cur_v_q);
    assign seed_req[e] = !used_q[e];
    assign walk_req[e] = !used_q[e] && at_cur &&
                         ((color_q[e] & lvl_mask) == prefix_q);
  end

  logic           seed_found, walk_found;
  logic [EIW-1:0] seed_idx, walk_idx;

  ec_find_first #(.W(NE), .IW(EIW)) u_seed_pick (
    .req (seed_req), .found (seed_found), .idx (seed_idx)
  );
  ec_find_first #(.W(NE), .IW(EIW)) u_walk_pick (
    .req (walk_req), .found (walk_found), .idx (walk_idx)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    level_d   = level_q;
    cur_v_d   = cur_v_q;
    side_d    = side_q;
    half_d    = half_q;
    prefix_d  = prefix_q;
    done_d    = 1'b0;
    clr_used  = 1'b0;
    clr_color = 1'b0;
    set_en    = 1'b0;
    set_idx   = walk_idx;
    set_val   = half_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          clr_color = 1'b1;
          clr_used  = 1'b1;
          level_d   = '0;
          if (LOG == 0) done_d  = 1'b1;
          else          state_d = ST_SEED;
        end
      end
      ST_SEED: begin
        if (seed_found) begin
          cur_v_d  = left_q[seed_idx];
          side_d   = 1'b0;
          half_d   = 1'b0;
          prefix_d = color_q[seed_idx] & lvl_mask;
          state_d  = ST_WALK;
        end else if (int'(level_q) == LOG - 1) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          level_d  = level_q + 1'b1;
          clr_used = 1'b1;
        end
      end
      ST_WALK: begin
        if (walk_found) begin
          set_en  = 1'b1;
          cur_v_d = side_q ? left_q[walk_idx] : right_q[walk_idx];
          side_d  = ~side_q;
          half_d  = ~half_q;
        end else begin
          state_d = ST_SEED;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_IDLE;
      level_q  <= '0;
      cur_v_q  <= '0;
      side_q   <= 1'b0;
      half_q   <= 1'b0;
      prefix_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      level_q  <= level_d;
      cur_v_q  <= cur_v_d;
      side_q   <= side_d;
      half_q   <= half_d;
      prefix_q <= prefix_d;
      done_q   <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_color = color_q[rd_idx];
endmodule

// File: rtl/ec_colorer_chk.sv
module ec_colorer_chk #(
  parameter int EIW = 4,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [EIW-1:0] rd_idx,
  input logic [CW-1:0]  rd_color
);
  // R5: done only shows while the block is idle.
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: done lasts a single cycle.
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a run only ends together with done.
  p_end_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4: an accepted start launches a run (or finishes at once when nothing to split).
  p_start_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  // R7: colors stay put while idle without a start.
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ((rd_idx != $past(rd_idx)) || $stable(rd_color)));
endmodule

bind euler_edge_colorer ec_colorer_chk #(.EIW(EIW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rd_idx   (rd_idx),
  .rd_color (rd_color)
);

// File: tb/euler_edge_colorer_test.sv
module euler_edge_colorer_test;
  localparam int CLK_P = 10;
  localparam int NV    = 4;
  localparam int DEG   = 4;
  localparam int NE    = NV * DEG;
  localparam int EIW   = $clog2(NE);
  localparam int VW    = $clog2(NV);
  localparam int LOG   = $clog2(DEG);
  localparam int CW    = LOG;
  localparam int BOUND = LOG * (2 * NE + 1) + 1;
  localparam int NVEC  = 6;
  // Each entry: {pattern[3:2], rotation[1:0]}
  localparam logic [3:0] VEC [NVEC] = '{4'b00_00, 4'b01_01, 4'b10_10,
                                        4'b11_11, 4'b00_10, 4'b10_01};

  logic clk, rst_n, wr_en, start, busy, done;
  logic [EIW-1:0] wr_idx, rd_idx;
  logic [VW-1:0]  wr_left, wr_right;
  logic [CW-1:0]  rd_color;

  int checks = 0, failures = 0, cycles = 0;
  int gl [NE];
  int gr [NE];
  int col [NE];
  int saved [NE];

  euler_edge_colorer #(.NV(NV), .DEG(DEG)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_left(wr_left), .wr_right(wr_right), .start(start),
    .busy(busy), .done(done), .rd_idx(rd_idx), .rd_color(rd_color)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat_left(input int code, input int e);
    int a = e / DEG, b = e % DEG;
    return (code == 3) ? b : a;
  endfunction

  function automatic int pat_right(input int code, input int rot, input int e);
    int a = e / DEG, b = e % DEG, r;
    case (code)
      0, 3: r = (a + b) % NV;
      1:    r = a;
      default: r = (b >= 2) ? (a ^ 1) : a;
    endcase
    return (r + rot) % NV;
  endfunction

  task automatic write_edge(input int idx, input int l, input int r);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = EIW'(idx); wr_left = VW'(l); wr_right = VW'(r);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R3: bogus pass first, then the real endpoints overwrite it.
  task automatic load_graph(input int code, input int rot);
    for (int e = 0; e < NE; e++) write_edge(e, 0, 0);
    for (int e = 0; e < NE; e++) begin
      int pos = (e * 5 + rot) % NE;
      gl[pos] = pat_left(code, e);
      gr[pos] = pat_right(code, rot, e);
      write_edge(pos, gl[pos], gr[pos]);
    end
  endtask

  // Pulse start, optionally disturb mid-run; returns cycles to done and done count.
  task automatic run(input bit disturb, output int lat, output int ndone);
    lat = 0; ndone = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy after start", int'(busy), 1);
    lat = 1;
    while (!done && lat < 1000) begin
      if (disturb && lat == 5) begin
        wr_en = 1'b1; wr_idx = 3; wr_left = VW'(gl[3] ^ 1); wr_right = VW'(gr[3] ^ 2);
        start = 1'b1;
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    wr_en = 1'b0; start = 1'b0;
    if (done) begin
      ndone++;
      check("R5 busy low with done", int'(busy), 0);
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
  endtask

  task automatic read_colors();
    for (int e = 0; e < NE; e++) begin
      rd_idx = EIW'(e);
      #1;
      col[e] = int'(rd_color);
    end
  endtask

  task automatic check_coloring(input string tag);
    int cl = 0, cr = 0, bad_cnt = 0, out_rng = 0;
    int cnt [DEG];
    for (int c = 0; c < DEG; c++) cnt[c] = 0;
    for (int i = 0; i < NE; i++) begin
      if (col[i] < 0 || col[i] >= DEG) out_rng++;
      else cnt[col[i]]++;
      for (int j = i + 1; j < NE; j++) begin
        if (gl[i] == gl[j] && col[i] == col[j]) cl++;
        if (gr[i] == gr[j] && col[i] == col[j]) cr++;
      end
    end
    for (int c = 0; c < DEG; c++) if (cnt[c] != NV) bad_cnt++;
    check({"R1 left clashes ", tag}, cl, 0);
    check({"R1 right clashes ", tag}, cr, 0);
    check({"R2 range ", tag}, out_rng, 0);
    check({"R2 class size ", tag}, bad_cnt, 0);
  endtask

  initial begin
    int lat, nd, diffs;
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0;
    wr_idx = '0; wr_left = '0; wr_right = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 busy at reset", int'(busy), 0);
    check("R7 done at reset", int'(done), 0);
    read_colors();
    diffs = 0;
    for (int e = 0; e < NE; e++) if (col[e] != 0) diffs++;
    check("R7 colors zero at reset", diffs, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1, R2, R3, R5
    for (int v = 0; v < NVEC; v++) begin
      load_graph(int'(VEC[v][3:2]), int'(VEC[v][1:0]));
      run(1'b0, lat, nd);
      check("R5 done count", nd, 1);
      check("R5 latency in bound", int'(lat <= BOUND + 1), 1);
      read_colors();
      check_coloring($sformatf("vec%0d", v));
    end

    // R7: colors hold while idle
    for (int e = 0; e < NE; e++) saved[e] = col[e];
    repeat (20) @(negedge clk);
    read_colors();
    diffs = 0;
    for (int e = 0; e < NE; e++) if (col[e] != saved[e]) diffs++;
    check("R7 idle hold", diffs, 0);

    // R6: rerun with a write and a start while busy; colors must match
    run(1'b1, lat, nd);
    check("R6 single done under disturbance", nd, 1);
    read_colors();
    diffs = 0;
    for (int e = 0; e < NE; e++) if (col[e] != saved[e]) diffs++;
    check("R6 colors unchanged by busy write", diffs, 0);
    check_coloring("r6_rerun");

    finish_run();
  end
endmodule